// File: doc/BRIEF.md
# Dual Event Counter Monitor

This block watches a core's event and stall lines with two 32-bit counters. Each counter is set up through a shared control register: an 8-bit code selects one event line, a mode bit chooses between counting event onsets and counting cycles during which a condition stays high, and two enable bits allow counting in supervisor mode, in user mode, or in both. One power bit starts and halts both counters without changing any of their fields. A chain bit turns the pair into a 64-bit count, where the upper counter advances on each wrap of the lower one.

Software reads and writes the two count registers and the control register through a simple word-addressed register port. Reads are combinational and return the value held before the current clock edge. A write to a count register loads it directly, for example to clear it. The counters raise no interrupt and wrap silently.

Top module: `perf_counter_pair`

## Requirements
- R1: After reset, both count registers and the control register read as zero.
- R2: Byte offset 0 reads counter 0, offset 4 reads counter 1 and offset 8 reads the control register; any other offset reads zero. In the control register, counter 0 uses bits [10:0]: event code [7:0], mode bit 8, supervisor enable bit 9 and user enable bit 10. Counter 1 uses the same layout at bits [26:16]. Bit 30 is chain and bit 31 is power. All other bits are stored as zero.
- R3: With mode bit 1 (occurrence), a counter adds one in each cycle where its selected event line is high and was low in the previous cycle.
- R4: With mode bit 0 (duration), a counter adds one in every cycle where its selected line is high.
- R5: The input privSuper=1 means supervisor mode and 0 means user mode. A counter counts only when the enable bit for the current mode is set.
- R6: While power (bit 31) is 0, neither counter changes, and the other control fields keep their values.
- R7: Codes at or above NUM_EVENTS (160 by default) never count, even when every line is high. Code 159 counts normally.
- R8: Without chaining, a counter at 0xFFFFFFFF that counts becomes 0, and the other counter is unaffected.
- R9: With chain set, counter 1 ignores its own selection and advances exactly when counter 0 wraps from 0xFFFFFFFF to 0.
- R10: A write to a count register takes priority over an increment or a chain carry in the same cycle, and reads in that cycle return the old value.
- R11: Writing zero to the control register stops all counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (4) | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| privSuper | input | 1 | Current privilege: 1 supervisor, 0 user |
| eventIn | input | NUM_EVENTS (160) | Event and stall lines, indexed by code |

## Verification
The hardest cases to reach are the cycles where counter 0 sits at 0xFFFFFFFF, counts, and a carry or a software write lands in the same cycle. Waiting for the counter to reach that value is not practical. The stimulus preloads the count registers just below the wrap point, holds a duration event high, and places a write to counter 1 exactly on the carry cycle. A behavioural model runs in parallel with random event traffic, random privilege and random register writes, and it compares every read, so onsets and held levels are covered under both privilege modes.

// File: rtl/perf_counter_pair_pkg.sv
package perf_counter_pair_pkg;
  localparam int NUM_CNT   = 2;
  localparam int CODE_W    = 8;
  localparam int FLD_W     = 11;
  localparam int MODE_BIT  = 8;
  localparam int SUP_BIT   = 9;
  localparam int USR_BIT   = 10;
  localparam int CNT1_OFS  = 16;
  localparam int CHAIN_BIT = 30;
  localparam int PWR_BIT   = 31;
  localparam int OFS_CNT0  = 0;
  localparam int OFS_CNT1  = 4;
  localparam int OFS_CTRL  = 8;
  localparam logic [31:0] FLD_ONES  = 32'((1 << FLD_W) - 1);
  localparam logic [31:0] CTRL_MASK = (32'h1 << PWR_BIT) | (32'h1 << CHAIN_BIT) |
                                      (FLD_ONES << CNT1_OFS) | FLD_ONES;

  typedef struct packed {
    logic inc0;
    logic inc1;
    logic chain;
    logic wr0;
    logic wr1;
  } pmonStrobe_t;
endpackage

// File: rtl/perf_counter_pair_ctrl.sv
module perf_counter_pair_ctrl
  import perf_counter_pair_pkg::*;
#(
  parameter int NUM_EVENTS = 160,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWdata,
  input  logic                  privSuper,
  input  logic [NUM_EVENTS-1:0] eventIn,
  output logic [31:0]           ctrlReg,
  output pmonStrobe_t           strb
);
  localparam int EVT_SPACE = 1 << CODE_W;
  localparam logic [ADDR_W-1:0] A_CNT0 = ADDR_W'(OFS_CNT0);
  localparam logic [ADDR_W-1:0] A_CNT1 = ADDR_W'(OFS_CNT1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic [NUM_EVENTS-1:0] evtPrev;
  logic [EVT_SPACE-1:0]  evtNow, evtOld;
  logic [NUM_CNT-1:0]    incVec;
  logic                  ctrlWr;

  assign evtNow = EVT_SPACE'(eventIn);
  assign evtOld = EVT_SPACE'(evtPrev);
  assign ctrlWr = busWe && (busAddr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      evtPrev <= '0;
    end else begin
      evtPrev <= eventIn;
      if (ctrlWr) ctrlReg <= busWdata & CTRL_MASK;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_sel
    logic [FLD_W-1:0]  fld;
    logic [CODE_W-1:0] code;
    logic              lvl, old, hit, privOk;
    assign fld    = ctrlReg[n*CNT1_OFS +: FLD_W];
    assign code   = fld[CODE_W-1:0];
    assign lvl    = evtNow[code];
    assign old    = evtOld[code];
    assign hit    = fld[MODE_BIT] ? (lvl && !old) : lvl;
    assign privOk = privSuper ? fld[SUP_BIT] : fld[USR_BIT];
    assign incVec[n] = ctrlReg[PWR_BIT] && privOk && hit;
  end

  always_comb begin
    strb.inc0  = incVec[0];
    strb.inc1  = incVec[1];
    strb.chain = ctrlReg[CHAIN_BIT];
    strb.wr0   = busWe && (busAddr == A_CNT0);
    strb.wr1   = busWe && (busAddr == A_CNT1);
  end

  // R6
  power_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[PWR_BIT] |-> !strb.inc0 && !strb.inc1);

  // R11
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata == 32'h0) |=> !strb.inc0 && !strb.inc1 && ctrlReg == 32'h0);
endmodule

// File: rtl/perf_counter_pair_dp.sv
module perf_counter_pair_dp
  import perf_counter_pair_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmonStrobe_t       strb,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cnt0,
  output logic [CNT_W-1:0]  cnt1
);
  logic carry0, adv1;

  assign carry0 = strb.inc0 && !strb.wr0 && (&cnt0);
  assign adv1   = strb.chain ? carry0 : strb.inc1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else begin
      if (strb.wr0)      cnt0 <= wrData;
      else if (strb.inc0) cnt0 <= cnt0 + 1'b1;
      if (strb.wr1)      cnt1 <= wrData;
      else if (adv1)     cnt1 <= cnt1 + 1'b1;
    end
  end

  // R10
  wr_prio0_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr0 |=> cnt0 == $past(wrData));

  // R10
  wr_prio1_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr1 |=> cnt1 == $past(wrData));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr0 |=> (cnt0 == $past(cnt0)) || (cnt0 == CNT_W'($past(cnt0) + 1'b1)));

  // R9
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.chain && !strb.wr1 && !(strb.inc0 && !strb.wr0 && (&cnt0))) |=> $stable(cnt1));

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc0 && !strb.wr0 && (&cnt0)) |=> cnt0 == '0);
endmodule

// File: rtl/perf_counter_pair.sv
module perf_counter_pair
  import perf_counter_pair_pkg::*;
#(
  parameter int NUM_EVENTS = 160,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic                  privSuper,
  input  logic [NUM_EVENTS-1:0] eventIn
);
  localparam logic [ADDR_W-1:0] A_CNT0 = ADDR_W'(OFS_CNT0);
  localparam logic [ADDR_W-1:0] A_CNT1 = ADDR_W'(OFS_CNT1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  pmonStrobe_t strb;
  logic [31:0] ctrlReg, cnt0, cnt1;

  perf_counter_pair_ctrl #(.NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .privSuper(privSuper), .eventIn(eventIn), .ctrlReg(ctrlReg), .strb(strb)
  );

  perf_counter_pair_dp #(.CNT_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata), .cnt0(cnt0), .cnt1(cnt1)
  );

  always_comb begin
    unique case (busAddr)
      A_CNT0:  busRdata = cnt0;
      A_CNT1:  busRdata = cnt1;
      A_CTRL:  busRdata = ctrlReg;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: tb/perf_counter_pair_test.sv
`timescale 1ns/1ps
module perf_counter_pair_test;
  localparam int NE = 160;
  localparam logic [31:0] MASK = 32'hC7FF07FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic privSuper = 1'b1;
  logic [NE-1:0] eventIn = '0;

  always #10 clk = ~clk;

  perf_counter_pair uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .privSuper(privSuper), .eventIn(eventIn)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";
  bit litEn = 0;
  logic [31:0] litVal;

  logic [31:0] mCtrl = '0, mC0 = '0, mC1 = '0;
  logic [NE-1:0] mPrev = '0;

  function automatic logic [31:0] mRead(logic [3:0] a);
    case (a)
      4'd0: return mC0;
      4'd4: return mC1;
      4'd8: return mCtrl;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit mInc(int n);
    logic [31:0] f = mCtrl >> (16 * n);
    int code = int'(f[7:0]);
    bit lvl = (code < NE) ? eventIn[code] : 1'b0;
    bit old = (code < NE) ? mPrev[code] : 1'b0;
    bit hit = f[8] ? (lvl && !old) : lvl;
    bit ok  = privSuper ? f[9] : f[10];
    return mCtrl[31] && ok && hit;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, busAddr, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [3:0] a, logic [31:0] wd, logic [NE-1:0] ev, bit pr);
    bit i0, i1, w0, w1, wc, carry;
    logic [31:0] n0, n1, nc;
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = wd; eventIn = ev; privSuper = pr;
    #1;
    check(tag, busRdata, mRead(a));
    if (litEn) check(tag, busRdata, litVal);
    litEn = 0;
    i0 = mInc(0); i1 = mInc(1);
    w0 = we && a == 4'd0; w1 = we && a == 4'd4; wc = we && a == 4'd8;
    carry = i0 && !w0 && (mC0 == 32'hFFFFFFFF);
    n0 = w0 ? wd : mC0 + {31'b0, i0};
    n1 = w1 ? wd : mC1 + {31'b0, (mCtrl[30] ? carry : i1)};
    nc = wc ? (wd & MASK) : mCtrl;
    @(posedge clk);
    mC0 = n0; mC1 = n1; mCtrl = nc; mPrev = ev;
  endtask

  task automatic peek(string req, logic [3:0] a, logic [31:0] exp);
    tag = req; litEn = 1; litVal = exp;
    cyc(0, a, 32'h0, '0, 1'b1);
  endtask

  function automatic logic [NE-1:0] rndEvt();
    logic [NE-1:0] v;
    for (int k = 0; k < NE; k += 32) v[k +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [NE-1:0] one(int code);
    logic [NE-1:0] v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc(1, a, d, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    peek("R1", 4'd0, 32'h0);
    peek("R1", 4'd4, 32'h0);
    peek("R1", 4'd8, 32'h0);

    // R2 layout: only defined bits stored; unmapped offset reads zero
    tag = "R2";
    wr(4'd8, 32'hFFFFFFFF);
    peek("R2", 4'd8, 32'hC7FF07FF);
    peek("R2", 4'd12, 32'h0);
    tag = "R11";
    wr(4'd8, 32'h0);
    peek("R11", 4'd8, 32'h0);

    // R3 occurrence: counter0 code 0x0D, both modes enabled
    tag = "R3";
    wr(4'd8, 32'h8206070D);
    wr(4'd0, 32'h0);
    repeat (4) cyc(0, 4'd0, 0, one(13), 1'b1);
    cyc(0, 4'd0, 0, '0, 1'b1);
    repeat (2) cyc(0, 4'd0, 0, one(13), 1'b0);
    peek("R3", 4'd0, 32'd2);

    // R4 duration on counter1 code 0x06, R5 supervisor only
    tag = "R4";
    wr(4'd4, 32'h0);
    repeat (3) cyc(0, 4'd4, 0, one(6), 1'b1);
    tag = "R5";
    repeat (3) cyc(0, 4'd4, 0, one(6), 1'b0);
    peek("R5", 4'd4, 32'd3);

    // R3/R4/R5 random traffic
    tag = "R5";
    for (int k = 0; k < 60; k++) cyc(0, 4'(4 * (k % 3)), 0, rndEvt(), 1'($urandom));

    // R6 power off holds everything
    tag = "R6";
    wr(4'd8, 32'h0206070D);
    for (int k = 0; k < 20; k++) cyc(0, 4'(4 * (k % 3)), 0, rndEvt(), 1'($urandom));
    peek("R6", 4'd8, 32'h0206070D);

    // R7 unimplemented code 0xA5 vs last code 159
    tag = "R7";
    wr(4'd8, 32'h869F06A5);
    wr(4'd0, 32'h0);
    wr(4'd4, 32'h0);
    repeat (10) cyc(0, 4'd0, 0, '1, 1'b1);
    peek("R7", 4'd0, 32'h0);
    peek("R7", 4'd4, 32'd10);

    // R8 unchained wrap
    tag = "R8";
    wr(4'd8, 32'h86FF0609);
    wr(4'd4, 32'h0000_0055);
    wr(4'd0, 32'hFFFFFFFE);
    repeat (3) cyc(0, 4'd0, 0, one(9), 1'b1);
    peek("R8", 4'd0, 32'd1);
    peek("R8", 4'd4, 32'h55);

    // R9 chained: counter1 own event held high but ignored
    tag = "R9";
    wr(4'd8, 32'hC69F0609);
    wr(4'd4, 32'd5);
    wr(4'd0, 32'hFFFFFFFE);
    repeat (3) cyc(0, 4'd4, 0, one(9) | one(159), 1'b1);
    peek("R9", 4'd4, 32'd6);
    peek("R9", 4'd0, 32'd1);

    // R10 write wins over increment and over carry
    tag = "R10";
    cyc(1, 4'd0, 32'h1234, one(9), 1'b1);
    peek("R10", 4'd0, 32'h1234);
    wr(4'd0, 32'hFFFFFFFF);
    cyc(1, 4'd4, 32'h77, one(9), 1'b1);
    peek("R10", 4'd4, 32'h77);
    peek("R10", 4'd0, 32'h0);

    // R11 control cleared stops counting
    tag = "R11";
    wr(4'd8, 32'h0);
    for (int k = 0; k < 10; k++) cyc(0, 4'(4 * (k % 3)), 0, '1, 1'($urandom));

    // R2 mixed random writes and reads across the map
    tag = "R2";
    for (int k = 0; k < 300; k++) begin
      bit w = ($urandom % 6) == 0;
      logic [3:0] a = 4'(4 * ($urandom % 4));
      logic [31:0] d = $urandom;
      if (w && a == 4'd8) d[31] = 1'b1;
      if (w && a == 4'd0 && d[0]) d = 32'hFFFFFFFD;
      cyc(w, a, d, rndEvt(), 1'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule